// File: doc/BRIEF.md
# Flash query and ID read multiplexer

This block decides what a read on the flash bus returns, given the mode the flash command state machine is in. A read can return array contents, the status byte, one of a small set of identifier words, or one byte of a little-endian geometry query table. That table has a fixed header and is followed by one 4-byte descriptor for each configured erase region. The descriptors are derived on the fly from each region's block count and block size, so software sees a consistent geometry whatever the region configuration is.

Reads arrive as requests on a valid/ready channel that carries the mode, the byte address and the array word the storage produced for that address. Each accepted request yields exactly one response beat on a valid/ready channel, together with a flag that marks a query or identifier address with nothing mapped there. The block holds one response and stalls new requests while that response is held. Fixed device parameters (identifiers, table addresses, voltages, timeouts, size, interface code, buffer length) are module parameters. The erase-region configuration comes in on ports.

Top module: `flash_rd_mux`

## Requirements
- R1: In array mode (mode code 0) the response data equals `arr_data` as presented with the accepted request, and the flag is 0.
- R2: In status mode (code 3) and erase-setup mode (code 4) the response carries `status_byte` in bits 7:0 with all higher bits zero, and the flag is 0.
- R3: The word address is the byte address shifted right by log2(DATA_W/8). In query mode (code 2) word address 0x10+k returns table byte k. The fixed part is 29 bytes: 0x51, 0x52, 0x59 at k=0..2; primary ID at 3..4; primary table address at 5..6; alternate ID at 7..8; alternate address at 9..10; four voltage bytes at 11..14; eight timeout bytes at 15..22; log2 device size at 23; interface code at 24..25; log2 max buffer length at 26..27; effective region count at 28. All multi-byte fields are low byte first.
- R4: Region r is described at k = 29+4r. Bytes 0..1 hold (block count − 1) and bytes 2..3 hold (block size / 256), both 16-bit little-endian.
- R5: The effective region count is `rgn_count` limited to NREG. A query read with a word address below 0x10 or at or above 0x10 + 29 + 4×count returns all-zero data with the flag set.
- R6: Every query response has all bits above bit 7 equal to zero.
- R7: In identifier mode (code 1), the word address masked to its low 9 bits selects: 0 → MANUF_ID, 1 → 0x00AD, 2 → 0x0000, 5 → 0x8000.
- R8: An identifier read at any other masked address returns zero with the flag set.
- R9: The flag is set only on a response beat (never while `rsp_valid` is 0). It is never set in array, status or erase-setup mode. The reserved mode codes 5..7 return zero data with the flag clear.
- R10: Address bits below the word boundary do not affect the response.
- R11: `req_ready` is high when no response is held or the held one is taken in the same cycle. An accepted request gives `rsp_valid` on the next cycle. While `rsp_valid` is high and `rsp_ready` is low, the data and flag stay unchanged.
- R12: After reset `rsp_valid` and `rsp_unmapped` are 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_mode | input | 3 | Current flash mode code |
| req_byte_addr | input | ADDR_W | Byte address of the read |
| arr_data | input | DATA_W | Array word for this address |
| status_byte | input | 8 | Current status register |
| rgn_count | input | $clog2(NREG+1) | Configured erase-region count |
| rgn_blocks | input | NREG*17 | Per-region block count, region r at [17r +: 17] |
| rgn_bytes | input | NREG*24 | Per-region block size in bytes, region r at [24r +: 24] |
| rsp_valid | output | 1 | Response beat present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | DATA_W | Read result |
| rsp_unmapped | output | 1 | Query/identifier address had nothing mapped |

## Verification
The bench builds the block with DATA_W = 32, NREG = 4, ADDR_W = 24 and MANUF_ID = 0x0020, and gives every fixed header field a distinct byte value. With a 4-byte bus the word address is the byte address shifted by two, so low-address-bit independence and the zeroing of three upper bytes in query mode can both be observed. A region count field 3 bits wide reaches values above NREG, which exercises the clamp. With four regions that include a block count of 65536 and a size of 0xFFFF00, the 16-bit truncation of the descriptors and the last descriptor byte before the window end are both reachable.

// File: rtl/frm_pkg.sv
package frm_pkg;
  localparam logic [2:0] MD_ARRAY  = 3'd0;
  localparam logic [2:0] MD_IDENT  = 3'd1;
  localparam logic [2:0] MD_QUERY  = 3'd2;
  localparam logic [2:0] MD_STATUS = 3'd3;
  localparam logic [2:0] MD_ERASE  = 3'd4;

  localparam int QRY_BASE  = 16;   // word address of table byte 0
  localparam int FIXED_LEN = 29;   // bytes in the fixed table header
  localparam int BLK_W     = 17;   // block count field width
  localparam int SZ_W      = 24;   // block size field width
  localparam logic [15:0] DEV_CODE = 16'h00AD;
  localparam logic [15:0] CFG_WORD = 16'h8000;
endpackage

// File: rtl/frm_qtable.sv
module frm_qtable
  import frm_pkg::*;
#(
  parameter int          NREG     = 4,
  parameter int          OFF_W    = 6,
  parameter int          CNT_W    = 3,
  parameter logic [15:0] PRI_ID   = 16'h0003,
  parameter logic [15:0] PRI_TBL  = 16'h0000,
  parameter logic [15:0] ALT_ID   = 16'h0000,
  parameter logic [15:0] ALT_TBL  = 16'h0000,
  parameter logic [31:0] VOLT     = 32'h0,
  parameter logic [63:0] TMO      = 64'h0,
  parameter logic [7:0]  DEV_LOG2 = 8'd22,
  parameter logic [15:0] IFACE    = 16'h0000,
  parameter logic [15:0] BUF_LOG2 = 16'h0000
) (
  input  logic [OFF_W-1:0]      off,
  input  logic [CNT_W-1:0]      cnt_eff,
  input  logic [NREG*BLK_W-1:0] blocks,
  input  logic [NREG*SZ_W-1:0]  sizes,
  output logic [7:0]            q_byte
);
  localparam int DESC_N = 4 * NREG;
  localparam int DIDX_W = $clog2(DESC_N);

  logic [7:0] desc [DESC_N];

  // One little-endian descriptor per region, computed from its config
  for (genvar r = 0; r < NREG; r++) begin : g_desc
    logic [15:0] cnt_m1;
    logic [15:0] sz_units;
    assign cnt_m1   = 16'(blocks[r*BLK_W +: BLK_W] - 17'd1);
    assign sz_units = 16'(sizes[r*SZ_W +: SZ_W] >> 8);
    assign desc[4*r+0] = cnt_m1[7:0];
    assign desc[4*r+1] = cnt_m1[15:8];
    assign desc[4*r+2] = sz_units[7:0];
    assign desc[4*r+3] = sz_units[15:8];
  end

  logic [OFF_W-1:0] doff;
  assign doff = off - OFF_W'(FIXED_LEN);

  always_comb begin
    q_byte = 8'h00;
    if (off < OFF_W'(FIXED_LEN)) begin
      case (int'(off))
        0:  q_byte = 8'h51;
        1:  q_byte = 8'h52;
        2:  q_byte = 8'h59;
        3:  q_byte = PRI_ID[7:0];
        4:  q_byte = PRI_ID[15:8];
        5:  q_byte = PRI_TBL[7:0];
        6:  q_byte = PRI_TBL[15:8];
        7:  q_byte = ALT_ID[7:0];
        8:  q_byte = ALT_ID[15:8];
        9:  q_byte = ALT_TBL[7:0];
        10: q_byte = ALT_TBL[15:8];
        11: q_byte = VOLT[7:0];
        12: q_byte = VOLT[15:8];
        13: q_byte = VOLT[23:16];
        14: q_byte = VOLT[31:24];
        15: q_byte = TMO[7:0];
        16: q_byte = TMO[15:8];
        17: q_byte = TMO[23:16];
        18: q_byte = TMO[31:24];
        19: q_byte = TMO[39:32];
        20: q_byte = TMO[47:40];
        21: q_byte = TMO[55:48];
        22: q_byte = TMO[63:56];
        23: q_byte = DEV_LOG2;
        24: q_byte = IFACE[7:0];
        25: q_byte = IFACE[15:8];
        26: q_byte = BUF_LOG2[7:0];
        27: q_byte = BUF_LOG2[15:8];
        default: q_byte = 8'(cnt_eff);
      endcase
    end else if (doff < OFF_W'(DESC_N)) begin
      q_byte = desc[doff[DIDX_W-1:0]];
    end
  end
endmodule

// File: rtl/frm_ident.sv
module frm_ident
  import frm_pkg::*;
#(
  parameter logic [15:0] MANUF_ID = 16'h0089
) (
  input  logic [8:0]  id_addr,
  output logic [15:0] id_word,
  output logic        id_hit
);
  always_comb begin
    id_hit  = 1'b1;
    id_word = 16'h0000;
    case (id_addr)
      9'd0:    id_word = MANUF_ID;
      9'd1:    id_word = DEV_CODE;
      9'd2:    id_word = 16'h0000;   // lock state: unlocked
      9'd5:    id_word = CFG_WORD;
      default: id_hit  = 1'b0;
    endcase
  end
endmodule

// File: rtl/frm_rsp_slot.sv
module frm_rsp_slot #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         din_flag,
  input  logic         take,
  output logic         vld,
  output logic [W-1:0] dout,
  output logic         dflag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld   <= 1'b0;
      dout  <= '0;
      dflag <= 1'b0;
    end else if (load) begin
      vld   <= 1'b1;
      dout  <= din;
      dflag <= din_flag;
    end else if (take) begin
      vld   <= 1'b0;
      dflag <= 1'b0;
    end
  end
endmodule

// File: rtl/flash_rd_mux.sv
module flash_rd_mux
  import frm_pkg::*;
#(
  parameter int          DATA_W   = 16,
  parameter int          ADDR_W   = 24,
  parameter int          NREG     = 4,
  parameter logic [15:0] MANUF_ID = 16'h0089,
  parameter logic [15:0] PRI_ID   = 16'h0003,
  parameter logic [15:0] PRI_TBL  = 16'h0000,
  parameter logic [15:0] ALT_ID   = 16'h0000,
  parameter logic [15:0] ALT_TBL  = 16'h0000,
  parameter logic [31:0] VOLT     = 32'h0,
  parameter logic [63:0] TMO      = 64'h0,
  parameter logic [7:0]  DEV_LOG2 = 8'd22,
  parameter logic [15:0] IFACE    = 16'h0000,
  parameter logic [15:0] BUF_LOG2 = 16'h0000,
  localparam int         CNT_W    = $clog2(NREG + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [2:0]            req_mode,
  input  logic [ADDR_W-1:0]     req_byte_addr,
  input  logic [DATA_W-1:0]     arr_data,
  input  logic [7:0]            status_byte,
  input  logic [CNT_W-1:0]      rgn_count,
  input  logic [NREG*BLK_W-1:0] rgn_blocks,
  input  logic [NREG*SZ_W-1:0]  rgn_bytes,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [DATA_W-1:0]     rsp_data,
  output logic                  rsp_unmapped
);
  localparam int BYTES = DATA_W / 8;
  localparam int SHIFT = $clog2(BYTES);
  localparam int OFF_W = $clog2(FIXED_LEN + 4 * NREG);
  localparam int IDW   = (DATA_W < 16) ? DATA_W : 16;

  logic [ADDR_W-1:0] wa;
  logic [CNT_W-1:0]  cnt_eff;
  logic [ADDR_W-1:0] q_end;
  logic              in_q;
  logic [OFF_W-1:0]  q_off;
  logic [7:0]        q_byte;
  logic [15:0]       id_word;
  logic              id_hit;
  logic [DATA_W-1:0] nxt_data;
  logic              nxt_flag;
  logic              accept;

  assign wa      = req_byte_addr >> SHIFT;
  assign cnt_eff = (rgn_count > CNT_W'(NREG)) ? CNT_W'(NREG) : rgn_count;
  assign q_end   = ADDR_W'(QRY_BASE + FIXED_LEN) + (ADDR_W'(cnt_eff) << 2);
  assign in_q    = (wa >= ADDR_W'(QRY_BASE)) && (wa < q_end);
  assign q_off   = OFF_W'(wa - ADDR_W'(QRY_BASE));

  frm_qtable #(
    .NREG(NREG), .OFF_W(OFF_W), .CNT_W(CNT_W),
    .PRI_ID(PRI_ID), .PRI_TBL(PRI_TBL), .ALT_ID(ALT_ID), .ALT_TBL(ALT_TBL),
    .VOLT(VOLT), .TMO(TMO), .DEV_LOG2(DEV_LOG2), .IFACE(IFACE),
    .BUF_LOG2(BUF_LOG2)
  ) u_qtab (
    .off(q_off), .cnt_eff(cnt_eff), .blocks(rgn_blocks),
    .sizes(rgn_bytes), .q_byte(q_byte)
  );

  frm_ident #(.MANUF_ID(MANUF_ID)) u_id (
    .id_addr(wa[8:0]), .id_word(id_word), .id_hit(id_hit)
  );

  always_comb begin
    nxt_data = '0;
    nxt_flag = 1'b0;
    case (req_mode)
      MD_ARRAY: nxt_data = arr_data;
      MD_STATUS, MD_ERASE: nxt_data[7:0] = status_byte;
      MD_QUERY: begin
        if (in_q) nxt_data[7:0] = q_byte;
        else      nxt_flag      = 1'b1;
      end
      MD_IDENT: begin
        if (id_hit) nxt_data[IDW-1:0] = id_word[IDW-1:0];
        else        nxt_flag          = 1'b1;
      end
      default: nxt_data = '0;
    endcase
  end

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  frm_rsp_slot #(.W(DATA_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .load(accept), .din(nxt_data),
    .din_flag(nxt_flag), .take(rsp_ready), .vld(rsp_valid),
    .dout(rsp_data), .dflag(rsp_unmapped)
  );
endmodule

// File: rtl/flash_rd_mux_chk.sv
module flash_rd_mux_chk
  import frm_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [2:0]        req_mode,
  input logic [7:0]        status_byte,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic              rsp_unmapped
);
  logic [2:0] last_mode;
  logic [7:0] last_st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_mode <= MD_ARRAY;
      last_st   <= 8'h00;
    end else if (req_valid && req_ready) begin
      last_mode <= req_mode;
      last_st   <= status_byte;
    end
  end

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_unmapped));

  p_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  p_flag_beat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_unmapped |-> rsp_valid);

  p_flag_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_unmapped |-> rsp_data == '0);

  p_noflag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && last_mode != MD_QUERY && last_mode != MD_IDENT |-> !rsp_unmapped);

  p_status_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (last_mode == MD_STATUS || last_mode == MD_ERASE)
      |-> rsp_data == DATA_W'(last_st));

  if (DATA_W > 8) begin : g_hi
    p_query_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && last_mode == MD_QUERY |-> rsp_data[DATA_W-1:8] == '0);
  end
endmodule

bind flash_rd_mux flash_rd_mux_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_mode(req_mode), .status_byte(status_byte), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_unmapped(rsp_unmapped)
);

// File: tb/flash_rd_mux_tb.sv
module flash_rd_mux_tb;
  localparam int DW = 32;
  localparam int AW = 24;
  localparam int NR = 4;
  localparam logic [15:0] T_MANUF = 16'h0020;
  localparam logic [15:0] T_PID   = 16'h0302;
  localparam logic [15:0] T_PTBL  = 16'h0504;
  localparam logic [15:0] T_AID   = 16'h0706;
  localparam logic [15:0] T_ATBL  = 16'h0908;
  localparam logic [31:0] T_VOLT  = 32'h0D0C0B0A;
  localparam logic [63:0] T_TMO   = 64'h1514131211100F0E;
  localparam logic [7:0]  T_DEV   = 8'h16;
  localparam logic [15:0] T_IF    = 16'h1817;
  localparam logic [15:0] T_BUF   = 16'h1A19;
  localparam logic [NR*17-1:0] T_BLK = {17'd300, 17'd65536, 17'd1, 17'd8};
  localparam logic [NR*24-1:0] T_SZ  = {24'hFFFF00, 24'h000100, 24'h002000, 24'h010000};

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, rsp_ready = 0;
  logic [2:0] req_mode = 0;
  logic [AW-1:0] req_byte_addr = 0;
  logic [DW-1:0] arr_data = 0;
  logic [7:0] status_byte = 0;
  logic [2:0] rgn_count = 4;
  logic req_ready, rsp_valid, rsp_unmapped;
  logic [DW-1:0] rsp_data;
  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  flash_rd_mux #(
    .DATA_W(DW), .ADDR_W(AW), .NREG(NR), .MANUF_ID(T_MANUF), .PRI_ID(T_PID),
    .PRI_TBL(T_PTBL), .ALT_ID(T_AID), .ALT_TBL(T_ATBL), .VOLT(T_VOLT),
    .TMO(T_TMO), .DEV_LOG2(T_DEV), .IFACE(T_IF), .BUF_LOG2(T_BUF)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_byte_addr(req_byte_addr), .arr_data(arr_data),
    .status_byte(status_byte), .rgn_count(rgn_count), .rgn_blocks(T_BLK),
    .rgn_bytes(T_SZ), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .rsp_unmapped(rsp_unmapped)
  );

  task automatic chk(input string req, input logic [DW:0] act, input logic [DW:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int ceff(input logic [2:0] c);
    return (int'(c) > NR) ? NR : int'(c);
  endfunction

  function automatic logic [7:0] qbyte(input int k, input logic [2:0] c);
    logic [16:0] b;
    int r, j;
    case (k)
      0: return 8'h51;  1: return 8'h52;  2: return 8'h59;
      3: return T_PID[7:0];   4: return T_PID[15:8];
      5: return T_PTBL[7:0];  6: return T_PTBL[15:8];
      7: return T_AID[7:0];   8: return T_AID[15:8];
      9: return T_ATBL[7:0];  10: return T_ATBL[15:8];
      23: return T_DEV;
      24: return T_IF[7:0];   25: return T_IF[15:8];
      26: return T_BUF[7:0];  27: return T_BUF[15:8];
      28: return 8'(ceff(c));
      default: ;
    endcase
    if (k >= 11 && k <= 14) return T_VOLT[(k-11)*8 +: 8];
    if (k >= 15 && k <= 22) return T_TMO[(k-15)*8 +: 8];
    r = (k - 29) / 4;
    j = (k - 29) % 4;
    b = T_BLK[r*17 +: 17] - 17'd1;
    case (j)
      0: return b[7:0];
      1: return b[15:8];
      2: return T_SZ[r*24+8 +: 8];
      default: return T_SZ[r*24+16 +: 8];
    endcase
  endfunction

  // returns {flag, data}
  function automatic logic [DW:0] expect_rd(input logic [2:0] m, input logic [AW-1:0] a,
                                             input logic [DW-1:0] arr, input logic [7:0] st,
                                             input logic [2:0] c);
    int wa = int'(a >> 2);
    case (m)
      3'd0: return {1'b0, arr};
      3'd3, 3'd4: return {1'b0, 24'h0, st};
      3'd2: begin
        if (wa >= 16 && wa < 16 + 29 + 4*ceff(c)) return {1'b0, 24'h0, qbyte(wa-16, c)};
        return {1'b1, 32'h0};
      end
      3'd1: begin
        case (wa & 'h1FF)
          0: return {1'b0, 16'h0, T_MANUF};
          1: return {1'b0, 32'h000000AD};
          2: return {1'b0, 32'h0};
          5: return {1'b0, 32'h00008000};
          default: return {1'b1, 32'h0};
        endcase
      end
      default: return {1'b0, 32'h0};
    endcase
  endfunction

  task automatic rd(input string req, input logic [2:0] m, input logic [AW-1:0] a, input int stall);
    logic [DW:0] exp, held;
    int guard = 0;
    @(negedge clk);
    req_valid = 1; req_mode = m; req_byte_addr = a;
    arr_data = $urandom; status_byte = 8'($urandom);
    exp = expect_rd(m, a, arr_data, status_byte, rgn_count);
    while (!req_ready && guard < 50) begin @(negedge clk); guard++; end
    @(negedge clk);
    req_valid = 0;
    arr_data = $urandom; status_byte = 8'($urandom);
    chk("R11 valid after accept", {32'h0, rsp_valid}, {32'h0, 1'b1});
    held = {rsp_unmapped, rsp_data};
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk("R11 held beat", {rsp_unmapped, rsp_data}, held);
    end
    chk(req, {rsp_unmapped, rsp_data}, exp);
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    chk("R12 reset valid", {32'h0, rsp_valid}, 33'h0);
    chk("R12 reset flag", {32'h0, rsp_unmapped}, 33'h0);
    chk("R12 reset ready", {32'h0, req_ready}, 33'h1);
    rst_n = 1;

    rd("R1 array", 3'd0, 24'h000100, 0);
    rd("R2 status", 3'd3, 24'h000000, 0);
    rd("R2 erase-setup", 3'd4, 24'h000044, 2);
    rd("R3 Q", 3'd2, 24'h40, 0);
    rd("R3 R", 3'd2, 24'h44, 0);
    rd("R10 Y low bits", 3'd2, 24'h4B, 0);
    rd("R10 Q low bits", 3'd2, 24'h41, 0);
    for (int k = 3; k < 29; k++) rd("R3 header byte", 3'd2, AW'((16+k)*4), 0);
    for (int k = 29; k < 45; k++) rd("R4 region byte", 3'd2, AW'((16+k)*4), 0);
    rd("R5 below base", 3'd2, 24'h3C, 0);
    rd("R5 end full", 3'd2, AW'((16+45)*4), 0);
    rgn_count = 2;
    rd("R5 last in window", 3'd2, AW'((16+36)*4), 0);
    rd("R5 end two", 3'd2, AW'((16+37)*4), 0);
    rd("R3 count byte", 3'd2, AW'((16+28)*4), 0);
    rgn_count = 0;
    rd("R5 end zero", 3'd2, AW'((16+29)*4), 0);
    rgn_count = 7;
    rd("R5 clamp count", 3'd2, AW'((16+28)*4), 0);
    rd("R5 clamp last", 3'd2, AW'((16+44)*4), 0);
    rd("R5 clamp end", 3'd2, AW'((16+45)*4), 0);
    rgn_count = 4;
    rd("R7 manuf", 3'd1, 24'h0, 0);
    rd("R7 device", 3'd1, 24'h4, 1);
    rd("R7 lock", 3'd1, 24'h8, 0);
    rd("R7 cfg", 3'd1, 24'h14, 0);
    rd("R7 mask", 3'd1, AW'((512+1)*4), 0);
    rd("R8 unmapped id", 3'd1, 24'hC, 0);
    rd("R8 unmapped id hi", 3'd1, AW'(511*4), 3);
    rd("R9 reserved mode", 3'd6, 24'h40, 0);
    rd("R9 reserved mode 7", 3'd7, 24'hC, 0);

    for (int n = 0; n < 400; n++) begin
      logic [2:0] m = 3'($urandom_range(0, 7));
      logic [AW-1:0] a = ($urandom_range(0, 3) == 0) ? AW'($urandom) : AW'($urandom_range(0, 'h120));
      if (n % 50 == 0) rgn_count = 3'($urandom_range(0, 7));
      case (m)
        3'd0: rd("R1 random", m, a, $urandom_range(0, 2));
        3'd1: rd("R7 R8 random", m, a, $urandom_range(0, 2));
        3'd2: rd("R3 R4 R5 R6 random", m, a, $urandom_range(0, 2));
        3'd3, 3'd4: rd("R2 random", m, a, $urandom_range(0, 2));
        default: rd("R9 random", m, a, $urandom_range(0, 2));
      endcase
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule